// File: doc/BRIEF.md
# I2C Target Controller with Selectable Clock-Stretch Point

This block is the target side of an I2C link. It watches the SCL and SDA levels, recognises start and stop conditions, compares the first byte after a start with a programmable 7-bit address, and then moves data bytes in either direction. After each byte it holds SCL low, stretching the clock, until local software has acted. Each time a hold begins the block pulses an interrupt, and it pulses it again when a stop is seen.

Software chooses where in a received byte the hold falls. With the late point, the hold comes after the acknowledge clock. With the early point, it comes after the eighth data clock, so the acknowledge decision can still be changed while SCL is held. A hold ends in one of two ways. A data write releases SCL and, when transmitting, supplies the next byte. A release strobe also releases SCL, but when transmitting it drops transmit mode, so the block stops driving SDA. Both pins are open-drain. The outputs only say when to pull a line low.

Top module: `i2c_wait_target`

## Requirements
- R1: After reset, neither line is pulled low, `irq` is 0, every status flag is 0 and `rd_data` is 8'h00.
- R2: A start (SDA falling while SCL is high) sets `start_seen` and clears `stop_seen`. A stop (SDA rising while SCL is high) sets `stop_seen`, clears `start_seen` and pulses `irq`.
- R3: Bits [7:1] of the first byte after a start are compared with `own_addr`. On a match, SDA is pulled low on the 9th clock, `rd_data` takes the address byte, and SCL is held low after the 9th falling edge. On a mismatch there is no acknowledge, no hold and no drive until the next start.
- R4: `tx_mode` is set when a matching address byte has bit 0 = 1. It is cleared when bit 0 = 0, on a stop, and on a repeated start.
- R5: When receiving with `cfg_wait9`=1, SCL is held low after the 9th falling edge of each data byte, and `rd_data` holds that byte.
- R6: When receiving with `cfg_wait9`=0, SCL is held low after the 8th falling edge, with `rd_data` already valid. `cfg_ack_en` is taken during the following 9th clock, so it may be changed during the hold. No second hold follows in that byte.
- R7: For a received data byte, SDA is pulled low on the 9th clock exactly when `cfg_ack_en`=1.
- R8: While receiving, a hold ends on a `wr_data_en` pulse (any value, 8'hFF by convention) or a `rel_strobe` pulse. Every hold begins with a one-cycle `irq` pulse.
- R9: While transmitting, a `wr_data_en` pulse during the hold loads the byte and releases SCL. The byte goes out MSB first, and SDA changes only while SCL is low. The hold always falls after the 9th clock, whatever `cfg_wait9` is.
- R10: When transmitting, `ack_seen` becomes 1 if SDA is low at the 9th rising edge and 0 if it is high.
- R11: After a NACK on a transmitted byte, the block stops driving SDA, does not hold SCL, and raises no `irq` until the next start or stop.
- R12: A `rel_strobe` during a transmit hold clears `tx_mode`. The next byte is then received rather than driven, so SDA is not pulled low during its data bits.
- R13: A repeated start in the middle of a byte drops the partial byte and begins address reception again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL bus level |
| sda_i | input | 1 | SDA bus level |
| scl_drive_low | output | 1 | Pull SCL low (clock stretch) |
| sda_drive_low | output | 1 | Pull SDA low |
| own_addr | input | 7 | Address this target answers to |
| wr_data_en | input | 1 | Data write strobe |
| wr_data | input | 8 | Data written |
| rel_strobe | input | 1 | Release the hold without loading data |
| cfg_wait9 | input | 1 | 1: hold after the 9th clock, 0: after the 8th (receive) |
| cfg_ack_en | input | 1 | Acknowledge received data bytes |
| rd_data | output | 8 | Last received byte |
| irq | output | 1 | One-cycle event pulse |
| start_seen | output | 1 | Start condition detected |
| stop_seen | output | 1 | Stop condition detected |
| ack_seen | output | 1 | Acknowledge received on the last transmitted byte |
| tx_mode | output | 1 | Target is transmitting |

## Verification
Bus levels pass through two synchronizer flops and one edge-compare flop, so a hold, an acknowledge drive or a transmit bit appears three to four clocks after the SCL edge that causes it. The bench moves the bus only once every eight clocks and checks after that quarter period, so every result has settled. A release or write strobe acts at the next clock edge. Status is therefore read on the falling edge after the strobe, and a stretched SCL is followed by waiting on the wired bus level rather than by counting.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
   // One-cycle bus events decoded from the synchronized line levels.
   typedef struct packed {
      logic start;
      logic stop;
      logic rise;
      logic fall;
   } bus_evt_t;
endpackage

// File: rtl/i2cw_sync.sv
module i2cw_sync #(
   parameter int W      = 2,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] stg;

   // Idle bus lines are high, so the chain resets to ones.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= '1;
      else        stg <= {stg[STAGES-2:0], d};
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/i2cw_cond.sv
module i2cw_cond
   import i2cw_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     scl,
   input  logic     sda,
   output bus_evt_t evt
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl;
         sda_q <= sda;
      end
   end

   always_comb begin
      evt.start = scl & scl_q & sda_q & ~sda;
      evt.stop  = scl & scl_q & ~sda_q & sda;
      evt.rise  = ~scl_q & scl;
      evt.fall  = scl_q & ~scl;
   end
endmodule

// File: rtl/i2cw_engine.sv
module i2cw_engine
   import i2cw_pkg::*;
#(
   parameter int ADDR_W = 7,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  bus_evt_t          evt,
   input  logic              sda_lvl,
   input  logic [ADDR_W-1:0] own_addr,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rel,
   input  logic              wait9,
   input  logic              ack_en,
   output logic              scl_low,
   output logic              sda_low,
   output logic [DATA_W-1:0] rd_data,
   output logic              irq,
   output logic              start_seen,
   output logic              stop_seen,
   output logic              ack_seen,
   output logic              tx_mode
);
   localparam int CNT_W = $clog2(DATA_W + 2);
   localparam logic [CNT_W-1:0] LAST  = CNT_W'(DATA_W);
   localparam logic [CNT_W-1:0] LAST1 = CNT_W'(DATA_W + 1);

   logic              active;   // addressed, taking part in transfer
   logic              ign;      // NACK seen: silent until start/stop
   logic              is_addr;  // current byte is the address byte
   logic              ack_ph;   // between 8th and 9th falling edge
   logic              txv;      // transmit byte loaded
   logic              hold;
   logic [CNT_W-1:0]  bitn;     // rising edges seen in this byte
   logic [DATA_W-1:0] shreg;

   logic addr_hit, releasing, live;
   assign addr_hit  = (shreg[DATA_W-1 -: ADDR_W] == own_addr);
   assign releasing = hold & (wr_en | rel);
   assign live      = active & ~ign;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0; ign <= 1'b0; is_addr <= 1'b0; ack_ph <= 1'b0;
         txv <= 1'b0; hold <= 1'b0; bitn <= '0; shreg <= '0;
         rd_data <= '0; irq <= 1'b0; start_seen <= 1'b0; stop_seen <= 1'b0;
         ack_seen <= 1'b0; tx_mode <= 1'b0;
      end else begin
         irq <= 1'b0;
         if (evt.start) begin
            active <= 1'b1; ign <= 1'b0; is_addr <= 1'b1; ack_ph <= 1'b0;
            txv <= 1'b0; hold <= 1'b0; bitn <= '0; tx_mode <= 1'b0;
            ack_seen <= 1'b0; start_seen <= 1'b1; stop_seen <= 1'b0;
         end else if (evt.stop) begin
            active <= 1'b0; ign <= 1'b0; is_addr <= 1'b0; ack_ph <= 1'b0;
            txv <= 1'b0; hold <= 1'b0; bitn <= '0; tx_mode <= 1'b0;
            stop_seen <= 1'b1; start_seen <= 1'b0; irq <= 1'b1;
         end else begin
            // Hold release: a write loads the shifter when transmitting,
            // the strobe alone abandons transmit mode.
            if (releasing) begin
               hold <= 1'b0;
               if (tx_mode) begin
                  if (wr_en) begin
                     shreg <= wr_data;
                     txv   <= 1'b1;
                  end else begin
                     tx_mode <= 1'b0;
                     txv     <= 1'b0;
                  end
               end
            end
            if (live && evt.rise) begin
               if (bitn < LAST) begin
                  if (!tx_mode) shreg <= {shreg[DATA_W-2:0], sda_lvl};
                  bitn <= bitn + 1'b1;
               end else if (bitn == LAST) begin
                  if (tx_mode && !is_addr) begin
                     ack_seen <= ~sda_lvl;
                     ign      <= sda_lvl;
                  end
                  bitn <= bitn + 1'b1;
               end
            end
            if (live && evt.fall) begin
               if (bitn == LAST) begin
                  ack_ph <= 1'b1;
                  txv    <= 1'b0;
                  if (is_addr) begin
                     if (addr_hit) begin
                        rd_data <= shreg;
                        tx_mode <= shreg[0];
                     end else begin
                        active <= 1'b0;
                     end
                  end else if (!tx_mode) begin
                     rd_data <= shreg;
                     if (!wait9) begin
                        hold <= 1'b1;
                        irq  <= 1'b1;
                     end
                  end
               end else if (bitn == LAST1) begin
                  ack_ph  <= 1'b0;
                  bitn    <= '0;
                  is_addr <= 1'b0;
                  if (is_addr || tx_mode || wait9) begin
                     hold <= 1'b1;
                     irq  <= 1'b1;
                  end
               end else if (tx_mode && bitn != '0) begin
                  shreg <= {shreg[DATA_W-2:0], 1'b0};
               end
            end
         end
      end
   end

   assign scl_low = hold;
   assign sda_low = live & ((ack_ph & (is_addr | (~tx_mode & ack_en))) |
                            (tx_mode & txv & ~ack_ph & ~shreg[DATA_W-1]));
endmodule

// File: rtl/i2c_wait_target.sv
module i2c_wait_target
   import i2cw_pkg::*;
#(
   parameter int ADDR_W      = 7,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              scl_drive_low,
   output logic              sda_drive_low,
   input  logic [ADDR_W-1:0] own_addr,
   input  logic              wr_data_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rel_strobe,
   input  logic              cfg_wait9,
   input  logic              cfg_ack_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              irq,
   output logic              start_seen,
   output logic              stop_seen,
   output logic              ack_seen,
   output logic              tx_mode
);
   // Elaboration-time parameter checks.
   if (DATA_W != ADDR_W + 1) begin : g_bad_width
      $error("DATA_W must equal ADDR_W + 1 (address plus direction bit)");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [1:0] lines_s;
   bus_evt_t   evt;

   i2cw_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q(lines_s)
   );

   i2cw_cond u_cond (
      .clk(clk), .rst_n(rst_n), .scl(lines_s[1]), .sda(lines_s[0]), .evt(evt)
   );

   i2cw_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_eng (
      .clk(clk), .rst_n(rst_n), .evt(evt), .sda_lvl(lines_s[0]),
      .own_addr(own_addr), .wr_en(wr_data_en), .wr_data(wr_data),
      .rel(rel_strobe), .wait9(cfg_wait9), .ack_en(cfg_ack_en),
      .scl_low(scl_drive_low), .sda_low(sda_drive_low), .rd_data(rd_data),
      .irq(irq), .start_seen(start_seen), .stop_seen(stop_seen),
      .ack_seen(ack_seen), .tx_mode(tx_mode)
   );
endmodule

// File: rtl/i2cw_chk.sv
module i2cw_chk (
   input logic clk,
   input logic rst_n,
   input logic wr_data_en,
   input logic rel_strobe,
   input logic scl_drive_low,
   input logic irq,
   input logic tx_mode,
   input logic start_seen,
   input logic stop_seen
);
   a_r8_irq_at_hold: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(scl_drive_low) |-> irq);

   a_r8_release_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(scl_drive_low) |-> $past(wr_data_en | rel_strobe));

   a_r8_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);

   a_r12_rel_drops_tx: assert property (@(posedge clk) disable iff (!rst_n)
      (rel_strobe && !wr_data_en && scl_drive_low && tx_mode) |=> !tx_mode);

   a_r2_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(start_seen && stop_seen));
endmodule

bind i2c_wait_target i2cw_chk u_chk (.*);

// File: tb/sim_i2c_wait_target.sv
module sim_i2c_wait_target;
   localparam int CLK_P = 10;
   localparam int Q     = 8;
   localparam logic [6:0] OWN = 7'h52;

   // {addr, data, wait9, ack_en, use_rel}
   localparam logic [18:0] VEC [5] = '{
      {7'h52, 8'hA6, 1'b1, 1'b1, 1'b0},
      {7'h52, 8'h5B, 1'b0, 1'b1, 1'b1},
      {7'h52, 8'h00, 1'b0, 1'b0, 1'b0},
      {7'h52, 8'hFF, 1'b1, 1'b0, 1'b1},
      {7'h13, 8'h3C, 1'b1, 1'b1, 1'b0}
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic scl_m = 1'b1, sda_m = 1'b1;
   logic wr_data_en = 1'b0, rel_strobe = 1'b0, cfg_wait9 = 1'b1, cfg_ack_en = 1'b1;
   logic [7:0] wr_data = 8'h00;
   logic scl_drive_low, sda_drive_low, irq, start_seen, stop_seen, ack_seen, tx_mode;
   logic [7:0] rd_data;
   int nchk = 0, nfail = 0, irq_cnt = 0;

   wire scl_bus = scl_m & ~scl_drive_low;
   wire sda_bus = sda_m & ~sda_drive_low;

   always #(CLK_P/2) clk = ~clk;
   always @(posedge clk) if (rst_n && irq) irq_cnt <= irq_cnt + 1;

   i2c_wait_target u0 (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
      .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
      .own_addr(OWN), .wr_data_en(wr_data_en), .wr_data(wr_data),
      .rel_strobe(rel_strobe), .cfg_wait9(cfg_wait9), .cfg_ack_en(cfg_ack_en),
      .rd_data(rd_data), .irq(irq), .start_seen(start_seen), .stop_seen(stop_seen),
      .ack_seen(ack_seen), .tx_mode(tx_mode)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wait_q();
      repeat (Q) @(negedge clk);
   endtask

   task automatic scl_up();
      scl_m = 1'b1;
      while (!scl_bus) @(negedge clk);
      wait_q();
   endtask

   task automatic do_start();
      sda_m = 1'b1; wait_q();
      scl_up();
      sda_m = 1'b0; wait_q();
      scl_m = 1'b0; wait_q();
   endtask

   task automatic do_stop();
      sda_m = 1'b0; wait_q();
      scl_up();
      sda_m = 1'b1; wait_q();
   endtask

   task automatic bit_io(input logic b, output logic r);
      sda_m = b; wait_q();
      scl_up();
      r = sda_bus;
      scl_m = 1'b0; wait_q();
   endtask

   task automatic send8(input logic [7:0] d);
      logic r;
      for (int i = 7; i >= 0; i--) bit_io(d[i], r);
   endtask

   task automatic read8(output logic [7:0] d);
      for (int i = 7; i >= 0; i--) bit_io(1'b1, d[i]);
   endtask

   task automatic pulse_wr(input logic [7:0] d);
      @(negedge clk); wr_data = d; wr_data_en = 1'b1;
      @(negedge clk); wr_data_en = 1'b0;
   endtask

   task automatic pulse_rel();
      @(negedge clk); rel_strobe = 1'b1;
      @(negedge clk); rel_strobe = 1'b0;
   endtask

   task automatic release_hold(input logic use_rel);
      if (use_rel) pulse_rel(); else pulse_wr(8'hFF);
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
   end

   initial begin
      logic r;
      logic [7:0] d;
      int i0;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 scl_drive_low", scl_drive_low, 0);
      chk("R1 sda_drive_low", sda_drive_low, 0);
      chk("R1 irq", irq, 0);
      chk("R1 flags", {start_seen, stop_seen, ack_seen, tx_mode}, 0);
      chk("R1 rd_data", rd_data, 0);
      rst_n = 1'b1;
      wait_q();

      // Vector table: write transfers
      for (int v = 0; v < 5; v++) begin
         logic [6:0] a; logic [7:0] dv; logic w9, ae, ur, hit;
         {a, dv, w9, ae, ur} = VEC[v];
         hit = (a == OWN);
         cfg_wait9 = w9;
         cfg_ack_en = w9 ? ae : ~ae;
         i0 = irq_cnt;
         do_start();
         chk("R2 start_seen", start_seen, 1);
         chk("R2 stop_seen cleared", stop_seen, 0);
         send8({a, 1'b0});
         bit_io(1'b1, r);
         chk("R3 address ack", r, hit ? 0 : 1);
         chk("R3 hold after address", scl_drive_low, hit);
         if (hit) begin
            chk("R4 tx_mode for write", tx_mode, 0);
            chk("R3 rd_data address", rd_data, {a, 1'b0});
            release_hold(ur);
            chk("R8 released", scl_drive_low, 0);
            send8(dv);
            if (!w9) begin
               chk("R6 hold after 8th", scl_drive_low, 1);
               chk("R6 rd_data", rd_data, dv);
               cfg_ack_en = ae;
               release_hold(ur);
            end else begin
               chk("R5 no hold at 8th", scl_drive_low, 0);
            end
            bit_io(1'b1, r);
            chk("R7 data ack", r, ae ? 0 : 1);
            if (w9) begin
               chk("R5 hold after 9th", scl_drive_low, 1);
               chk("R5 rd_data", rd_data, dv);
               release_hold(ur);
            end else begin
               chk("R6 no second hold", scl_drive_low, 0);
            end
         end
         do_stop();
         chk("R2 stop_seen", stop_seen, 1);
         chk("R2 start_seen cleared", start_seen, 0);
         chk("R8 irq count", irq_cnt - i0, hit ? 3 : 1);
      end

      // Transmit with ACK then NACK
      cfg_wait9 = 1'b0; cfg_ack_en = 1'b1;
      do_start();
      send8({OWN, 1'b1});
      bit_io(1'b1, r);
      chk("R3 read address ack", r, 0);
      chk("R4 tx_mode set", tx_mode, 1);
      chk("R9 hold before first byte", scl_drive_low, 1);
      pulse_wr(8'hA5);
      read8(d);
      chk("R9 transmitted byte", d, 8'hA5);
      chk("R9 no hold at 8th in transmit", scl_drive_low, 0);
      bit_io(1'b0, r);
      chk("R10 ack_seen after ACK", ack_seen, 1);
      chk("R9 hold after 9th in transmit", scl_drive_low, 1);
      pulse_wr(8'h3C);
      read8(d);
      chk("R9 second byte", d, 8'h3C);
      bit_io(1'b1, r);
      chk("R10 ack_seen after NACK", ack_seen, 0);
      chk("R11 no hold after NACK", scl_drive_low, 0);
      chk("R11 SDA released", sda_drive_low, 0);
      i0 = irq_cnt;
      read8(d);
      chk("R11 ignored byte", d, 8'hFF);
      chk("R11 no irq", irq_cnt - i0, 0);
      do_stop();
      chk("R4 tx_mode cleared by stop", tx_mode, 0);

      // Release strobe during a transmit hold
      cfg_wait9 = 1'b1; cfg_ack_en = 1'b0;
      do_start();
      send8({OWN, 1'b1});
      bit_io(1'b1, r);
      pulse_wr(8'h00);
      read8(d);
      chk("R9 zero byte", d, 8'h00);
      bit_io(1'b0, r);
      chk("R9 hold after ACK", scl_drive_low, 1);
      pulse_rel();
      chk("R12 tx_mode dropped", tx_mode, 0);
      chk("R12 released", scl_drive_low, 0);
      read8(d);
      chk("R12 SDA not driven", d, 8'hFF);
      bit_io(1'b1, r);
      chk("R7 no ack when disabled", r, 1);
      chk("R5 receive hold after 9th", scl_drive_low, 1);
      pulse_rel();
      do_stop();

      // Repeated start mid-byte
      cfg_ack_en = 1'b1;
      do_start();
      send8({OWN, 1'b0});
      bit_io(1'b1, r);
      pulse_wr(8'hFF);
      bit_io(1'b1, r); bit_io(1'b0, r); bit_io(1'b1, r);
      do_start();
      chk("R13 start_seen", start_seen, 1);
      send8({OWN, 1'b1});
      bit_io(1'b1, r);
      chk("R13 address after repeated start", r, 0);
      chk("R13 tx_mode", tx_mode, 1);
      chk("R13 hold", scl_drive_low, 1);
      pulse_wr(8'hFF);
      do_start();
      chk("R4 tx_mode cleared by repeated start", tx_mode, 0);
      do_stop();
      chk("R2 final stop", stop_seen, 1);

      summary();
      $finish;
   end
endmodule